// File: doc/BRIEF.md
# Legacy memory attribute decoder

This block sits in a host bridge and decides, for every memory access below 1 MiB, where the access goes. It can go to system DRAM, or it can be forwarded to the PCI side. If it is a write to a region marked read-only, it is dropped. The decision depends on three things: a set of attribute fields that configuration writes program, a system-management RAM (SMRAM) control byte, and a level input that says whether the processor is in system-management mode (SMM).

The address space is split into five parts. The top 64 KiB (0xF0000-0xFFFFF) is one segment with its own attribute. The range 0xC0000-0xEFFFF is twelve segments of 16 KiB, each with its own attribute. The 128 KiB window 0xA0000-0xBFFFF is steered by the SMRAM control byte and SMM. Everything else goes to DRAM.

The live map is held in a shadow register. A two-state controller reloads it whenever a configuration write touches one of the attribute or SMRAM bytes, or whenever the SMM input changes. Accesses are decoded against the shadow map and answered one cycle later.

The controller has two states:
- `ST_READY`: the shadow map is current.
- `ST_REMAP`: the shadow map is reloaded at the end of this cycle.

Its transitions are:
- READY→REMAP when a remap trigger is seen.
- REMAP→REMAP when another trigger arrives during a reload.
- REMAP→READY when no trigger is present.
- READY→READY otherwise.

The address layout assumes `N_EXP_SEG` = 12 and a 20-bit address.

Top module: `lmad_top`

## Requirements
- R1: After reset, every attribute field is 0, so all of 0xC0000-0xFFFFF goes to PCI. The SMRAM control byte resets to 0x02, so the 0xA0000-0xBFFFF window goes to PCI whatever the level of `smm_active`.
- R2: The attribute of segment 0xF0000-0xFFFFF is bits [5:4] of the configuration byte at offset 0x59.
- R3: Segment i (0..11) covers 0xC0000 + i·0x4000 to 0xC3FFF + i·0x4000. Its attribute comes from the byte at offset 0x5A + i/2. Even i uses bits [1:0] of that byte and odd i uses bits [5:4]. The other bits of these bytes are ignored.
- R4: The attribute codes mean the following:
  - 3: DRAM read/write.
  - 1: DRAM, reads only.
  - 0 and 2: forward to PCI.
- R5: A write to a segment with attribute 1 sets `rsp_drop`, with `rsp_dram` and `rsp_pci` both low. A read of that segment goes to DRAM.
- R6: The window 0xA0000-0xBFFFF goes to DRAM when bit 6 of the SMRAM byte (offset 0x72) is set, or when `smm_active` is high and bit 3 of that byte is set. Otherwise the window goes to PCI.
- R7: The addresses 0x00000-0x9FFFF always go to DRAM.
- R8: An access sampled with `acc_valid` high at a clock edge is answered in the following cycle. In that cycle `rsp_valid` is high and exactly one of `rsp_dram`, `rsp_pci` and `rsp_drop` is high. Without a sampled access, all four outputs are low.
- R9: A configuration write, or a change of `smm_active`, sampled at edge N affects accesses sampled at edge N+2 and later. Accesses sampled at edges N and N+1 still see the previous map.
- R10: Configuration writes to any offset other than 0x59-0x5F and 0x72 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| smm_active | input | 1 | System-management mode level |
| acc_valid | input | 1 | Memory access present |
| acc_addr | input | 20 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Decision valid (one cycle after the access) |
| rsp_dram | output | 1 | Access goes to DRAM |
| rsp_pci | output | 1 | Access is forwarded to PCI |
| rsp_drop | output | 1 | Write to a read-only segment, discarded |

## Verification
The hardest case to reach is the exact edge at which a new map takes effect. It falls two edges after the triggering write or SMM change, and only a back-to-back stream of accesses pressed against the trigger shows which edge switches. The bench aims one access at each of the two edges that follow a configuration write and an SMM toggle. It expects the old route for the early ones and the new route afterwards.

Beyond that, the bench sweeps both ends of every 16 KiB block, for reads and writes. The sweep runs across uniform and mixed attribute patterns, four SMRAM byte values and both SMM levels. The mixed patterns carry junk in the unused bits. Expected routes come from the bench's own model of the offsets and bit fields.

// File: rtl/lmad_pkg.sv
package lmad_pkg;

    // Decoded meaning of a segment attribute
    typedef enum logic [1:0] {
        SEG_PCI = 2'd0,
        SEG_RO  = 2'd1,
        SEG_RW  = 2'd2
    } seg_map_e;

    // Remap controller states
    typedef enum logic {
        ST_READY = 1'b0,
        ST_REMAP = 1'b1
    } remap_st_e;

    // Attribute field code -> segment meaning
    function automatic seg_map_e attr_to_map(input logic [1:0] code);
        seg_map_e m;
        unique case (code)
            2'd3:    m = SEG_RW;
            2'd1:    m = SEG_RO;
            default: m = SEG_PCI;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lmad_cfg_regs.sv
module lmad_cfg_regs #(
    parameter int CFG_AW     = 8,
    parameter int ATTR_BASE  = 'h59,
    parameter int ATTR_BYTES = 7,
    parameter int SMRAM_OFS  = 'h72,
    parameter int SMRAM_RST  = 'h02
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [CFG_AW-1:0]             addr,
    input  logic [7:0]                    wdata,
    output logic [ATTR_BYTES-1:0][7:0]    attr_q,
    output logic [7:0]                    smram_q,
    output logic                          touched
);
    localparam logic [CFG_AW-1:0] A_LO = CFG_AW'(ATTR_BASE);
    localparam logic [CFG_AW-1:0] A_HI = CFG_AW'(ATTR_BASE + ATTR_BYTES - 1);
    localparam logic [CFG_AW-1:0] S_AD = CFG_AW'(SMRAM_OFS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q  <= '0;
            smram_q <= 8'(SMRAM_RST);
        end else if (we) begin
            for (int b = 0; b < ATTR_BYTES; b++) begin
                if (addr == CFG_AW'(ATTR_BASE + b))
                    attr_q[b] <= wdata;
            end
            if (addr == S_AD)
                smram_q <= wdata;
        end
    end

    // A write that can change the map
    assign touched = we && (((addr >= A_LO) && (addr <= A_HI)) || (addr == S_AD));

endmodule

// File: rtl/lmad_map_build.sv
module lmad_map_build
    import lmad_pkg::*;
#(
    parameter int N_EXP_SEG  = 12,
    parameter int ATTR_BYTES = 7,
    parameter int N_SEG      = N_EXP_SEG + 1
) (
    input  logic [ATTR_BYTES-1:0][7:0] attr,
    input  logic [7:0]                 smram,
    input  logic                       smm,
    output logic [N_SEG-1:0][1:0]      seg_map,
    output logic                       win_open
);
    localparam int OPEN_BIT = 6;
    localparam int SMM_BIT  = 3;

    // Top 64 KiB segment: bits [5:4] of the first attribute byte
    assign seg_map[0] = attr_to_map(attr[0][5:4]);

    // Expansion segments: two per byte, even in low nibble, odd in high
    for (genvar i = 0; i < N_EXP_SEG; i++) begin : g_seg
        localparam int BI = 1 + i / 2;
        logic [1:0] code;
        if ((i % 2) == 0) begin : g_even
            assign code = attr[BI][1:0];
        end else begin : g_odd
            assign code = attr[BI][5:4];
        end
        assign seg_map[i+1] = attr_to_map(code);
    end

    assign win_open = smram[OPEN_BIT] | (smm & smram[SMM_BIT]);

    logic unused_fold;
    assign unused_fold = ^{attr, smram};

endmodule

// File: rtl/lmad_remap_fsm.sv
module lmad_remap_fsm
    import lmad_pkg::*;
#(
    parameter int N_SEG = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig,
    input  logic [N_SEG-1:0][1:0] next_map,
    input  logic                  next_open,
    output logic [N_SEG-1:0][1:0] cur_map,
    output logic                  cur_open
);
    remap_st_e st_q, st_d;
    logic      load;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_READY;
        else        st_q <= st_d;
    end

    // Next state and load strobe
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            ST_READY: begin
                if (trig) st_d = ST_REMAP;
            end
            ST_REMAP: begin
                load = 1'b1;
                st_d = trig ? ST_REMAP : ST_READY;
            end
            default: st_d = ST_READY;
        endcase
    end

    // Shadow map, consistent with reset configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < N_SEG; s++) cur_map[s] <= SEG_PCI;
            cur_open <= 1'b0;
        end else if (load) begin
            cur_map  <= next_map;
            cur_open <= next_open;
        end
    end

endmodule

// File: rtl/lmad_addr_dec.sv
module lmad_addr_dec
    import lmad_pkg::*;
#(
    parameter int N_EXP_SEG = 12,
    parameter int N_SEG     = N_EXP_SEG + 1,
    parameter int AW        = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic [AW-1:0]         acc_addr,
    input  logic                  acc_write,
    input  logic [N_SEG-1:0][1:0] cur_map,
    input  logic                  cur_open,
    output logic                  rsp_valid,
    output logic                  rsp_dram,
    output logic                  rsp_pci,
    output logic                  rsp_drop
);
    logic       in_hi, in_exp, in_win;
    logic [3:0] idx;
    logic [1:0] mode;
    logic       d_dram, d_pci, d_drop;

    assign in_hi  = (acc_addr[19:16] == 4'hF);
    assign in_exp = (acc_addr[19:18] == 2'b11) && !in_hi;
    assign in_win = (acc_addr[19:17] == 3'b101);
    assign idx    = acc_addr[17:14];

    always_comb begin
        mode = SEG_PCI;
        if (in_hi) begin
            mode = cur_map[0];
        end else if (in_exp) begin
            for (int s = 0; s < N_EXP_SEG; s++)
                if (idx == 4'(s)) mode = cur_map[s+1];
        end
    end

    always_comb begin
        d_dram = 1'b0;
        d_pci  = 1'b0;
        d_drop = 1'b0;
        if (in_win) begin
            d_dram = cur_open;
            d_pci  = !cur_open;
        end else if (in_hi || in_exp) begin
            unique case (mode)
                SEG_RW:  d_dram = 1'b1;
                SEG_RO: begin
                    d_drop = acc_write;
                    d_dram = !acc_write;
                end
                default: d_pci = 1'b1;
            endcase
        end else begin
            d_dram = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_dram  <= 1'b0;
            rsp_pci   <= 1'b0;
            rsp_drop  <= 1'b0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_dram  <= acc_valid & d_dram;
            rsp_pci   <= acc_valid & d_pci;
            rsp_drop  <= acc_valid & d_drop;
        end
    end

    logic unused_low;
    assign unused_low = ^acc_addr[13:0];

endmodule

// File: rtl/lmad_top.sv
module lmad_top
    import lmad_pkg::*;
#(
    parameter int CFG_AW    = 8,
    parameter int N_EXP_SEG = 12,
    parameter int ATTR_BASE = 'h59,
    parameter int SMRAM_OFS = 'h72,
    parameter int SMRAM_RST = 'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              smm_active,
    input  logic              acc_valid,
    input  logic [19:0]       acc_addr,
    input  logic              acc_write,
    output logic              rsp_valid,
    output logic              rsp_dram,
    output logic              rsp_pci,
    output logic              rsp_drop
);
    localparam int N_SEG      = N_EXP_SEG + 1;
    localparam int ATTR_BYTES = 1 + (N_EXP_SEG + 1) / 2;

    logic [ATTR_BYTES-1:0][7:0] attr_q;
    logic [7:0]                 smram_q;
    logic                       cfg_touch;
    logic                       smm_q;
    logic [N_SEG-1:0][1:0]      nxt_map, cur_map;
    logic                       nxt_open, cur_open;

    lmad_cfg_regs #(
        .CFG_AW(CFG_AW), .ATTR_BASE(ATTR_BASE), .ATTR_BYTES(ATTR_BYTES),
        .SMRAM_OFS(SMRAM_OFS), .SMRAM_RST(SMRAM_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .attr_q(attr_q), .smram_q(smram_q),
        .touched(cfg_touch)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) smm_q <= 1'b0;
        else        smm_q <= smm_active;
    end

    lmad_map_build #(
        .N_EXP_SEG(N_EXP_SEG), .ATTR_BYTES(ATTR_BYTES), .N_SEG(N_SEG)
    ) u_build (
        .attr(attr_q), .smram(smram_q), .smm(smm_q),
        .seg_map(nxt_map), .win_open(nxt_open)
    );

    lmad_remap_fsm #(.N_SEG(N_SEG)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .trig(cfg_touch | (smm_active ^ smm_q)),
        .next_map(nxt_map), .next_open(nxt_open),
        .cur_map(cur_map), .cur_open(cur_open)
    );

    lmad_addr_dec #(.N_EXP_SEG(N_EXP_SEG), .N_SEG(N_SEG), .AW(20)) u_dec (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write),
        .cur_map(cur_map), .cur_open(cur_open),
        .rsp_valid(rsp_valid), .rsp_dram(rsp_dram),
        .rsp_pci(rsp_pci), .rsp_drop(rsp_drop)
    );

endmodule

// File: rtl/lmad_chk.sv
module lmad_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic [19:0] acc_addr,
    input logic        acc_write,
    input logic        rsp_valid,
    input logic        rsp_dram,
    input logic        rsp_pci,
    input logic        rsp_drop
);
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_dram, rsp_pci, rsp_drop}) == 1)); // R8

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_dram | rsp_pci | rsp_drop)); // R8

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid); // R8

    AST_DROP_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> !rsp_drop); // R5

    AST_LOW_TO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_addr[19:17] < 3'b101)) |=> rsp_dram); // R7

endmodule

bind lmad_top lmad_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .rsp_valid(rsp_valid), .rsp_dram(rsp_dram),
    .rsp_pci(rsp_pci), .rsp_drop(rsp_drop)
);

// File: tb/sim_lmad_top.sv
module sim_lmad_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        smm_active = 1'b0;
    logic        acc_valid = 1'b0;
    logic [19:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        rsp_valid, rsp_dram, rsp_pci, rsp_drop;

    int errs = 0;
    int nchk = 0;
    bit done = 1'b0;

    logic [7:0] mb [7];
    logic [7:0] msm;

    always #10 clk = ~clk;

    lmad_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smm_active(smm_active), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write), .rsp_valid(rsp_valid),
        .rsp_dram(rsp_dram), .rsp_pci(rsp_pci), .rsp_drop(rsp_drop)
    );

    // Route codes: 1 DRAM, 2 PCI, 3 drop
    function automatic int exp_route(input logic [19:0] a, input bit wr);
        logic [1:0] code;
        logic [7:0] b;
        int i;
        if (a[19:16] == 4'hF) begin
            code = mb[0][5:4];
        end else if (a >= 20'hC0000) begin
            i = int'(a - 20'hC0000) / 'h4000;
            b = mb[1 + i / 2];
            code = (i % 2 == 1) ? b[5:4] : b[1:0];
        end else if (a >= 20'hA0000) begin
            return (msm[6] || (smm_active && msm[3])) ? 1 : 2;
        end else begin
            return 1;
        end
        if (code == 2'd3) return 1;
        if (code == 2'd1) return wr ? 3 : 1;
        return 2;
    endfunction

    function automatic string tag_of(input logic [19:0] a, input bit wr);
        if (a[19:16] == 4'hF) return (exp_route(a, wr) == 3) ? "R5" : "R2,R4";
        if (a >= 20'hC0000)   return (exp_route(a, wr) == 3) ? "R5" : "R3,R4";
        if (a >= 20'hA0000)   return "R6";
        return "R7";
    endfunction

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp,
                         input logic [19:0] a);
        nchk++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s addr=%05h got=%b expected=%b (valid,dram,pci,drop)",
                     tag, a, got, exp);
        end
    endtask

    function automatic logic [3:0] enc(input int r);
        return {1'b1, r == 1, r == 2, r == 3};
    endfunction

    // Called just after a negedge; returns just after the next negedge
    task automatic access(input logic [19:0] a, input bit wr, input int exp, input string tag);
        acc_valid = 1'b1;
        acc_addr  = a;
        acc_write = wr;
        @(negedge clk);
        check(tag, {rsp_valid, rsp_dram, rsp_pci, rsp_drop}, enc(exp), a);
        acc_valid = 1'b0;
    endtask

    task automatic cfg_wr(input logic [7:0] ad, input logic [7:0] d);
        cfg_we = 1'b1;
        cfg_addr = ad;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (ad >= 8'h59 && ad <= 8'h5F) mb[ad - 8'h59] = d;
        if (ad == 8'h72) msm = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic sweep(input string extra);
        for (int blk = 0; blk < 64; blk++) begin
            for (int off = 0; off < 2; off++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [19:0] a;
                    a = 20'(blk * 'h4000 + (off == 1 ? 'h3FFF : 0));
                    access(a, w[0], exp_route(a, w[0]),
                           (extra == "") ? tag_of(a, w[0]) : extra);
                end
            end
        end
    endtask

    initial begin
        logic [7:0] pat [6][7];
        logic [7:0] smv [4];
        pat[0] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        pat[1] = '{8'h10, 8'h11, 8'h11, 8'h11, 8'h11, 8'h11, 8'h11};
        pat[2] = '{8'h20, 8'h22, 8'h22, 8'h22, 8'h22, 8'h22, 8'h22};
        pat[3] = '{8'h30, 8'h33, 8'h33, 8'h33, 8'h33, 8'h33, 8'h33};
        pat[4] = '{8'hF7, 8'hD3, 8'h2C, 8'hF1, 8'h02, 8'hB3, 8'h50};
        pat[5] = '{8'hE7, 8'h9D, 8'h6B, 8'hF4, 8'h8E, 8'h57, 8'h3C};
        smv = '{8'h02, 8'h08, 8'h40, 8'h48};
        for (int b = 0; b < 7; b++) mb[b] = 8'h00;
        msm = 8'h02;

        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R8: idle outputs
        check("R8", {rsp_valid, rsp_dram, rsp_pci, rsp_drop}, 4'b0000, 20'h0);

        // R1: reset map, both SMM levels
        sweep("R1");
        smm_active = 1'b1;
        idle(3);
        sweep("R1");
        smm_active = 1'b0;
        idle(3);

        // Pattern x SMRAM x SMM sweeps (R2..R7)
        for (int p = 0; p < 6; p++) begin
            for (int b = 0; b < 7; b++) cfg_wr(8'(8'h59 + b), pat[p][b]);
            for (int s = 0; s < 4; s++) begin
                cfg_wr(8'h72, smv[s]);
                for (int m = 0; m < 2; m++) begin
                    smm_active = m[0];
                    idle(3);
                    sweep("");
                end
            end
        end

        // R10: writes to unrelated offsets change nothing
        cfg_wr(8'h58, 8'hFF);
        cfg_wr(8'h60, 8'hFF);
        cfg_wr(8'h71, 8'hFF);
        cfg_wr(8'h73, 8'hFF);
        cfg_wr(8'h00, 8'hFF);
        idle(3);
        sweep("R10");

        // R9: configuration write latency
        for (int b = 0; b < 7; b++) cfg_wr(8'(8'h59 + b), 8'h00);
        cfg_wr(8'h72, 8'h02);
        smm_active = 1'b0;
        idle(3);
        cfg_wr(8'h59, 8'h30);              // sampled at edge N
        access(20'hF1234, 1'b0, 2, "R9");  // edge N+1: old map
        access(20'hF1234, 1'b0, 1, "R9");  // edge N+2: new map

        // R9: SMM change latency
        cfg_wr(8'h72, 8'h08);
        idle(3);
        smm_active = 1'b1;                 // seen at edge N with this access
        access(20'hA4000, 1'b0, 2, "R9");
        access(20'hA4000, 1'b0, 2, "R9");
        access(20'hA4000, 1'b0, 1, "R9");
        smm_active = 1'b0;
        idle(3);
        access(20'hBFFFF, 1'b1, 2, "R6");

        // R8: quiet after traffic
        idle(1);
        check("R8", {rsp_valid, rsp_dram, rsp_pci, rsp_drop}, 4'b0000, 20'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            nchk++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end

endmodule